// File: doc/BRIEF.md
# Bit-Plane Block Compressor

This block takes a stream of 8-bit data words that have already had their zero values removed. It codes them in groups of eight into a lossless variable-length bit-plane code. Each word is first turned into its 9-bit difference from the word before it, so smooth data gives small differences. The eight differences of a group are then viewed sideways, as nine planes of eight bits each. Each plane is XORed with the plane above it. The resulting symbols are coded with a small prefix code that favours all-zero symbols and symbols with only one or two set bits. The code bits are packed most-significant-first into 8-bit output words, ready for a memory bus.

A finished group is parked in a one-entry holding stage. Words of the next group can therefore keep arriving while the encoder works through the parked group, one symbol per cycle. The previous group's last word serves as the base of the next group, so no base word is ever sent. A word marked as the end of a stream closes the current group early by repeating that word. It also forces the last output word out with zero fill and restarts the base at zero.

Top module: `bitplane_block_coder`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: Word i of the stream is coded as the 9-bit two's-complement difference d = word(i) - previous word. The previous word is 0 at the start of a stream, and it carries across group boundaries inside a stream.
- R3: Plane j (j = 0..8) holds bit j of the eight differences, with bit i of the plane taken from the group's i-th word. The symbol for plane 8 is that plane itself. The symbol for plane j < 8 is plane j XOR plane j+1. Symbols are coded from plane 8 down to plane 0.
- R4: Consecutive all-zero symbols are grouped greedily from the top, at most 5 per code. A group of 1 is coded as 01. A group of r = 2..5 is coded as 001 followed by r-2 in 2 bits. Longer runs are split into several codes.
- R5: A non-zero symbol with all bits set is coded as 00000. Otherwise, a non-zero symbol whose plane before the XOR is all zero is coded as 00001.
- R6: Failing R5, a symbol with exactly two set bits in adjacent positions is coded as 00010 plus the lower position in 3 bits. A symbol with one set bit is coded as 00011 plus its position in 3 bits.
- R7: Any other symbol is coded as 1 followed by its 8 bits, bit 7 first.
- R8: Code bits form one continuous stream across groups. The first bit of the stream lands in bit 7 of the first output word, and no bit is lost or added.
- R9: A word accepted with inFlush high ends its group, which is filled out with zero differences. The final output word of the stream is zero-filled. The next stream starts on a fresh output word with a base of 0.
- R10: While outValid is high and outReady is low, outValid stays high and outByte stays unchanged.
- R11: inReady goes low only when the offered word would close a group while the previous group is still parked waiting to be coded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Input word taken on this edge if inValid |
| inWord | input | WORD_W | Input data word |
| inFlush | input | 1 | Offered word is the last of its stream |
| outValid | output | 1 | Packed output word available |
| outReady | input | 1 | Consumer takes outByte on this edge |
| outByte | output | BYTE_W | Packed code bits, earliest bit in the MSB |

## Verification
The hardest state to reach is an input stall. It needs a group already parked, an encoder unable to move on, and an offered word that would close the next group. The stimulus holds outReady low and sends a group of irregular words whose first code already overfills the packer. It then offers seven more words, which must each be taken at once, and watches inReady stay low on the eighth until the output is released. Sweeps over ramp slopes and over single-word pulses at every position drive the all-ones, plane-zero, pair and single codes and every zero-run length. Partial groups of every length check the flush padding.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef struct packed {
    logic takeWord;
    logic closeBlock;
    logic resetBase;
    logic emitSym;
    logic padByte;
  } pdcCtrl_t;

endpackage

// File: rtl/pdc_control.sv
module pdc_control import pdc_pkg::*; #(
  parameter int BLOCK_N = 8,
  parameter int DW      = 9,
  parameter int RUN_K   = 2,
  localparam int IDXW   = $clog2(BLOCK_N),
  localparam int PW     = $clog2(DW),
  localparam int SW     = $clog2(DW + 1),
  localparam int RUNMAX = (1 << RUN_K) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inFlush,
  output logic            inReady,
  input  logic [SW-1:0]   symStep,
  input  logic            pkCanTake,
  input  logic            pkEmpty,
  output logic [IDXW-1:0] wordIdx,
  output logic [PW-1:0]   planeSel,
  output pdcCtrl_t        ctrl
);

  typedef enum logic {ST_RUN, ST_DRAIN} encSt_t;

  encSt_t st;
  logic   slotFull, slotLast;
  logic   lastPos, accept, closing, finishing;

  assign lastPos = (wordIdx == IDXW'(BLOCK_N - 1));
  assign inReady = !slotFull || (!inFlush && !lastPos);
  assign accept  = inValid && inReady;
  assign closing = accept && (inFlush || lastPos);

  assign ctrl.takeWord   = accept;
  assign ctrl.closeBlock = closing;
  assign ctrl.resetBase  = accept && inFlush;
  assign ctrl.emitSym    = (st == ST_RUN) && slotFull && pkCanTake;
  assign ctrl.padByte    = (st == ST_DRAIN);

  assign finishing = ctrl.emitSym && (int'(symStep) == int'(planeSel) + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      slotFull <= 1'b0;
      slotLast <= 1'b0;
      planeSel <= PW'(DW - 1);
      st       <= ST_RUN;
    end else begin
      if (accept) wordIdx <= closing ? '0 : wordIdx + 1'b1;
      if (closing) begin
        slotFull <= 1'b1;
        slotLast <= inFlush;
      end else if (finishing) begin
        slotFull <= 1'b0;
      end
      if (ctrl.emitSym) planeSel <= finishing ? PW'(DW - 1) : planeSel - PW'(symStep);
      if (finishing && slotLast) st <= ST_DRAIN;
      else if (st == ST_DRAIN && pkEmpty) st <= ST_RUN;
    end
  end

  // R4: every code consumes between one and RUNMAX planes and never passes plane 0
  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emitSym |-> (symStep != '0) && (int'(symStep) <= int'(planeSel) + 1) && (int'(symStep) <= RUNMAX));

  // R3: the plane pointer stays inside the plane set
  assert_plane_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(planeSel) < DW);

endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath import pdc_pkg::*; #(
  parameter int WORD_W  = 8,
  parameter int BLOCK_N = 8,
  parameter int RUN_K   = 2,
  parameter int BYTE_W  = 8,
  localparam int DW     = WORD_W + 1,
  localparam int IDXW   = $clog2(BLOCK_N),
  localparam int PW     = $clog2(DW),
  localparam int SW     = $clog2(DW + 1),
  localparam int RUNMAX = (1 << RUN_K) + 1,
  localparam int POSW   = IDXW,
  localparam int CODE_A = (1 + BLOCK_N > 5 + POSW) ? 1 + BLOCK_N : 5 + POSW,
  localparam int CODE_W = (CODE_A > 3 + RUN_K) ? CODE_A : 3 + RUN_K,
  localparam int LW     = $clog2(CODE_W + 1),
  localparam int ACC_W  = BYTE_W - 1 + CODE_W,
  localparam int FW     = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pdcCtrl_t          ctrl,
  input  logic [WORD_W-1:0] inWord,
  input  logic [IDXW-1:0]   wordIdx,
  input  logic [PW-1:0]     planeSel,
  input  logic              outReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [SW-1:0]     symStep,
  output logic              pkCanTake,
  output logic              pkEmpty
);

  // delta stage and collecting shift register
  logic [WORD_W-1:0]  baseWord;
  logic [DW-1:0]      deltaReg [BLOCK_N];
  logic [DW-1:0]      curDelta;
  logic [BLOCK_N-1:0] blockPlane [DW];
  logic [BLOCK_N-1:0] slotPlane [DW];
  logic [BLOCK_N-1:0] dbx [DW];

  assign curDelta = {1'b0, inWord} - {1'b0, baseWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseWord <= '0;
      for (int i = 0; i < BLOCK_N; i++) deltaReg[i] <= '0;
    end else if (ctrl.takeWord) begin
      deltaReg[wordIdx] <= curDelta;
      baseWord <= ctrl.resetBase ? '0 : inWord;
    end
  end

  // transpose of the closing block; words past the last one get zero deltas
  always_comb begin
    logic [DW-1:0] dSel;
    for (int i = 0; i < BLOCK_N; i++) begin
      if (i < int'(wordIdx))       dSel = deltaReg[i];
      else if (i == int'(wordIdx)) dSel = curDelta;
      else                         dSel = '0;
      for (int j = 0; j < DW; j++) blockPlane[j][i] = dSel[j];
    end
  end

  // depth-1 block holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DW; j++) slotPlane[j] <= '0;
    end else if (ctrl.closeBlock) begin
      for (int j = 0; j < DW; j++) slotPlane[j] <= blockPlane[j];
    end
  end

  for (genvar j = 0; j < DW; j++) begin : g_xor
    if (j == DW - 1) begin : g_top
      assign dbx[j] = slotPlane[j];
    end else begin : g_mid
      assign dbx[j] = slotPlane[j] ^ slotPlane[j + 1];
    end
  end

  // symbol encoder for the plane under planeSel
  logic [BLOCK_N-1:0] curX, curP;
  logic [CODE_W-1:0]  codeBits;
  logic [LW-1:0]      codeLen;
  int                 runLen, onesCnt, pairPos, singlePos;
  logic               stopRun, pairHit;

  assign curX = dbx[planeSel];
  assign curP = slotPlane[planeSel];

  always_comb begin
    runLen  = 0;
    stopRun = 1'b0;
    for (int k = 0; k < RUNMAX; k++) begin
      if (!stopRun) begin
        if (k > int'(planeSel))                        stopRun = 1'b1;
        else if (dbx[PW'(int'(planeSel) - k)] == '0)   runLen = runLen + 1;
        else                                           stopRun = 1'b1;
      end
    end
    onesCnt   = $countones(curX);
    pairHit   = 1'b0;
    pairPos   = 0;
    singlePos = 0;
    for (int i = 0; i < BLOCK_N - 1; i++) begin
      if (!pairHit && curX[i] && curX[i + 1]) begin
        pairHit = 1'b1;
        pairPos = i;
      end
    end
    for (int i = 0; i < BLOCK_N; i++) if (curX[i]) singlePos = i;

    if (runLen >= 2) begin
      codeBits = CODE_W'({3'b001, RUN_K'(runLen - 2)});
      codeLen  = LW'(3 + RUN_K);
    end else if (runLen == 1) begin
      codeBits = CODE_W'(2'b01);
      codeLen  = LW'(2);
    end else if (&curX) begin
      codeBits = '0;
      codeLen  = LW'(5);
    end else if (curP == '0) begin
      codeBits = CODE_W'(5'b00001);
      codeLen  = LW'(5);
    end else if (onesCnt == 2 && pairHit) begin
      codeBits = CODE_W'({5'b00010, POSW'(pairPos)});
      codeLen  = LW'(5 + POSW);
    end else if (onesCnt == 1) begin
      codeBits = CODE_W'({5'b00011, POSW'(singlePos)});
      codeLen  = LW'(5 + POSW);
    end else begin
      codeBits = CODE_W'({1'b1, curX});
      codeLen  = LW'(1 + BLOCK_N);
    end
  end

  assign symStep = SW'((runLen == 0) ? 1 : runLen);

  // byte packer, valid bits held left-aligned
  logic [ACC_W-1:0]  acc, placed;
  logic [CODE_W-1:0] codeLeft;
  logic [FW-1:0]     fill;
  logic              pop;

  assign codeLeft  = codeBits << (CODE_W - int'(codeLen));
  assign placed    = {codeLeft, {(ACC_W - CODE_W){1'b0}}} >> fill;
  assign pkCanTake = (fill < FW'(BYTE_W));
  assign pkEmpty   = (fill == '0);
  assign outValid  = (fill >= FW'(BYTE_W)) || (ctrl.padByte && fill != '0);
  assign outByte   = acc[ACC_W-1 -: BYTE_W];
  assign pop       = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      fill <= '0;
    end else if (pop) begin
      acc  <= acc << BYTE_W;
      fill <= (fill >= FW'(BYTE_W)) ? fill - FW'(BYTE_W) : '0;
    end else if (ctrl.emitSym) begin
      acc  <= acc | placed;
      fill <= fill + FW'(codeLen);
    end
  end

  // R10: an offered byte is held until taken
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte));

  // R8: the packer never holds more bits than its register
  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) <= ACC_W);

  // R8: a code is only appended while less than one byte is pending
  assert_push_room_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emitSym |-> fill < FW'(BYTE_W));

endmodule

// File: rtl/bitplane_block_coder.sv
module bitplane_block_coder import pdc_pkg::*; #(
  parameter int WORD_W  = 8,
  parameter int BLOCK_N = 8,
  parameter int RUN_K   = 2,
  parameter int BYTE_W  = 8,
  localparam int DW     = WORD_W + 1,
  localparam int IDXW   = $clog2(BLOCK_N),
  localparam int PW     = $clog2(DW),
  localparam int SW     = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inFlush,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outByte
);

  pdcCtrl_t        ctrl;
  logic [IDXW-1:0] wordIdx;
  logic [PW-1:0]   planeSel;
  logic [SW-1:0]   symStep;
  logic            pkCanTake, pkEmpty;

  pdc_control #(.BLOCK_N(BLOCK_N), .DW(DW), .RUN_K(RUN_K)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlush(inFlush), .inReady(inReady),
    .symStep(symStep), .pkCanTake(pkCanTake), .pkEmpty(pkEmpty),
    .wordIdx(wordIdx), .planeSel(planeSel), .ctrl(ctrl)
  );

  pdc_datapath #(.WORD_W(WORD_W), .BLOCK_N(BLOCK_N), .RUN_K(RUN_K), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inWord(inWord), .wordIdx(wordIdx),
    .planeSel(planeSel), .outReady(outReady), .outValid(outValid), .outByte(outByte),
    .symStep(symStep), .pkCanTake(pkCanTake), .pkEmpty(pkEmpty)
  );

endmodule

// File: tb/sim_bitplane_block_coder.sv
module sim_bitplane_block_coder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       inValid = 1'b0, inFlush = 1'b0, outReady = 1'b0;
  logic [7:0] inWord = '0;
  logic       inReady, outValid;
  logic [7:0] outByte;

  bitplane_block_coder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .inFlush(inFlush), .outValid(outValid), .outReady(outReady), .outByte(outByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0, lastWait = 0;
  string curTag = "R1";
  bit    holdOut = 1'b0, bpMode = 1'b0, started = 1'b0, holdPrev = 1'b0;
  logic [7:0]  heldByte = '0;
  logic [15:0] rdyLfsr = 16'hACE1, datLfsr = 16'h1D2B;

  // reference model state
  int         mIdx = 0;
  logic [7:0] mPrev = '0;
  logic [8:0] mD [8];
  bit         expBits [$];
  logic [7:0] expBytes [$];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nextData();
    datLfsr = {datLfsr[14:0], datLfsr[15] ^ datLfsr[13] ^ datLfsr[12] ^ datLfsr[10]};
    return datLfsr[7:0] ^ datLfsr[15:8];
  endfunction

  function automatic void putBits(input int v, input int n);
    for (int b = n - 1; b >= 0; b--) expBits.push_back(v[b]);
  endfunction

  function automatic void moveBytes(input bit pad);
    logic [7:0] by;
    if (pad) while (expBits.size() % 8 != 0) expBits.push_back(1'b0);
    while (expBits.size() >= 8) begin
      for (int b = 7; b >= 0; b--) by[b] = expBits.pop_front();
      expBytes.push_back(by);
    end
  endfunction

  function automatic void encodeBlock();
    logic [7:0] pl [9];
    logic [7:0] x [9];
    int p, r, c, pos;
    bit pair;
    for (int j = 0; j < 9; j++) for (int i = 0; i < 8; i++) pl[j][i] = mD[i][j];
    x[8] = pl[8];
    for (int j = 0; j < 8; j++) x[j] = pl[j] ^ pl[j + 1];
    p = 8;
    while (p >= 0) begin
      if (x[p] == 8'h00) begin
        r = 0;
        while (r < 5 && (p - r) >= 0 && x[p - r] == 8'h00) r++;
        if (r == 1) putBits(1, 2);
        else putBits(4 + (r - 2), 5);
        p -= r;
      end else begin
        c = $countones(x[p]);
        pair = 1'b0; pos = 0;
        for (int i = 0; i < 7; i++) if (!pair && x[p][i] && x[p][i + 1]) begin pair = 1'b1; pos = i; end
        if (c == 1) for (int i = 0; i < 8; i++) if (x[p][i]) pos = i;
        if (x[p] == 8'hFF)          putBits(0, 5);
        else if (pl[p] == 8'h00)    putBits(1, 5);
        else if (c == 2 && pair)    putBits(16 + pos, 8);
        else if (c == 1)            putBits(24 + pos, 8);
        else                        putBits(256 + int'(x[p]), 9);
        p--;
      end
    end
  endfunction

  function automatic void modelWord(input logic [7:0] w, input bit fl);
    mD[mIdx] = {1'b0, w} - {1'b0, mPrev};
    mPrev = w;
    if (fl || mIdx == 7) begin
      for (int i = mIdx + 1; i < 8; i++) mD[i] = '0;
      encodeBlock();
      moveBytes(fl);
      if (fl) mPrev = '0;
      mIdx = 0;
    end else begin
      mIdx++;
    end
  endfunction

  task automatic waitAccept();
    lastWait = 0;
    #1;
    while (!inReady) begin
      @(negedge clk); #1;
      lastWait++;
    end
    @(posedge clk);
  endtask

  task automatic sendWord(input logic [7:0] w, input bit fl);
    @(negedge clk);
    inValid = 1'b1; inWord = w; inFlush = fl;
    modelWord(w, fl);
    waitAccept();
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inFlush = 1'b0;
  endtask

  // output side: drive ready, then record the byte taken at the coming edge
  always @(negedge clk) begin
    if (started) begin
      if (holdPrev) begin
        check(outValid == 1'b1, "R10", "valid dropped while stalled", outValid, 1);
        check(outByte == heldByte, "R10", "byte changed while stalled", outByte, heldByte);
      end
      rdyLfsr = {rdyLfsr[14:0], rdyLfsr[15] ^ rdyLfsr[13] ^ rdyLfsr[12] ^ rdyLfsr[10]};
      outReady = holdOut ? 1'b0 : (bpMode ? rdyLfsr[0] : 1'b1);
      if (outValid && outReady) begin
        if (expBytes.size() == 0) check(1'b0, "R8", "unexpected byte", outByte, 0);
        else begin
          logic [7:0] e;
          e = expBytes.pop_front();
          check(outByte == e, curTag, "packed byte", outByte, e);
        end
      end
      holdPrev = outValid && !outReady;
      heldByte = outByte;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    started = 1'b1;

    // R11: output stalled, a parked block and a second block trying to close
    curTag = "R11";
    holdOut = 1'b1;
    for (int i = 0; i < 8; i++) sendWord(8'h5A ^ 8'(i * 37), 1'b0);
    for (int i = 0; i < 7; i++) begin
      sendWord(8'hC3 ^ 8'(i * 91), 1'b0);
      check(lastWait == 0, "R11", "mid-block word stalled", lastWait, 0);
    end
    @(negedge clk);
    inValid = 1'b1; inWord = 8'h3C; inFlush = 1'b0;
    modelWord(8'h3C, 1'b0);
    #1;
    check(inReady == 1'b0, "R11", "closing word accepted over full slot", inReady, 0);
    repeat (4) @(negedge clk);
    #1;
    check(inReady == 1'b0, "R11", "closing word accepted while stalled", inReady, 0);
    holdOut = 1'b0;
    waitAccept();
    sendWord(8'h11, 1'b1);

    // R4: an all-zero block gives runs of 5 then 4
    curTag = "R4";
    for (int i = 0; i < 8; i++) sendWord(8'h00, i == 7);

    // R2, R5: ramps of every slope in one stream, base carried across blocks
    curTag = "R2,R5";
    for (int s = 0; s < 256; s++)
      for (int i = 0; i < 8; i++) sendWord(8'(s * i + s), (s == 255 && i == 7));

    // R3, R6: a single pulse at each word position
    curTag = "R3,R6";
    for (int pos = 0; pos < 8; pos++)
      for (int v = 1; v < 256; v += 7)
        for (int i = 0; i < 8; i++) sendWord((i == pos) ? 8'(v) : 8'h00, (pos == 7 && v + 7 >= 256 && i == 7));

    // R7, R8: irregular data, many raw symbols
    curTag = "R7,R8";
    for (int b = 0; b < 200; b++)
      for (int i = 0; i < 8; i++) sendWord(nextData(), (b == 199 && i == 7));

    // R9: partial blocks of every length
    curTag = "R9";
    for (int len = 1; len <= 8; len++)
      for (int i = 0; i < len; i++) sendWord(nextData(), i == len - 1);

    // R10: random output backpressure
    curTag = "R10";
    bpMode = 1'b1;
    for (int b = 0; b < 40; b++)
      for (int i = 0; i < 8; i++) sendWord(nextData(), (b == 39 && i == 7));
    for (int len = 1; len <= 8; len++)
      for (int i = 0; i < len; i++) sendWord(nextData(), i == len - 1);
    idle();

    for (int n = 0; n < 4000 && (expBytes.size() != 0 || outValid); n++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(expBytes.size() == 0, "R8", "bytes missing at end", expBytes.size(), 0);
    check(outValid == 1'b0, "R9", "output left pending after flush", outValid, 0);
    summary();
    $finish;
  end
endmodule